// File: doc/BRIEF.md
# Request-Lost Interrupt Flag Dispatcher

This block gathers request-lost events from a set of channels. Each channel has two packets, A and B. Each event is a one-cycle pulse, and it sets a sticky bit in a single flag register. A per-bit enable mask decides which set flags drive the shared interrupt line. Masked flags are still captured and can still be read.

Software services the interrupt through a small register bus, in three steps:
- It reads an offset register. That register gives an interrupt-type code and the index of the lowest pending (set and enabled) flag.
- The same read clears that one flag in hardware.
- Any events that came in alongside or after the reported one stay visible in the flag register. Software clears them in a group by writing ones to the flag register.

The register bus is a plain strobe interface with no back-pressure, so every access completes in the cycle it is presented. Read data is combinational from the address, and a read has a side effect only when `bus_rd` is high at the clock edge. Flag index `2*channel + packet` is the value software decodes, so that ordering is fixed. Register addresses are 0 for the flags, 1 for the mask and 2 for the offset register.

Top module: `rlost_irq_dispatch`

## Requirements
- R1: An event pulse on `evt_a[c]` sets flag bit `2*c`, and one on `evt_b[c]` sets flag bit `2*c+1`; the bit reads as set from the cycle after the pulse's clock edge.
- R2: Flags are sticky: each stays set until cleared, and events on different channels in the same or later cycles accumulate.
- R3: Reading address 0 returns the flags in bits [2*NUM_CH-1:0], with all higher bits 0.
- R4: Writing address 0 clears every flag whose corresponding write-data bit is 1 and leaves the rest unchanged.
- R5: If an event and a clear (by write or by offset read) hit the same flag in the same cycle, the flag ends up set.
- R6: Address 2 returns the offset register, in which pending means set and enabled. When any flag is pending, bits [7:0] hold the lowest pending index and bits [11:8] hold type code 4'h3 (request lost). When nothing is pending, the whole word is 0.
- R7: A read strobe at address 2 clears only the reported flag, effective the next cycle. With nothing pending, the read strobe changes no flag.
- R8: Address 1 is a read/write enable mask that resets to all ones. `irq` is high exactly while some flag with its mask bit set is set. Masked flags are still captured and readable.
- R9: After reset all flags are 0 and `irq` is low.
- R10: Unmapped address 3 reads 0. Writes to address 3 or to the offset register change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_a | input | NUM_CH | Packet A request-lost pulses, one per channel |
| evt_b | input | NUM_CH | Packet B request-lost pulses, one per channel |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
Both single events and simultaneous events on different channels and packets are driven. Single events show that the index interleaving puts packet B one above packet A; simultaneous events show that flags accumulate and that the offset picks the lowest index. The dispatch sequence is replayed: the offset read reports only the first source and leaves the later ones set, and a grouped write-one clear empties the register. Colliding an event with a clear of the same bit tells event priority apart from clear priority. Masked flags separate capture from interrupt generation, and empty offset reads and writes to read-only or unmapped addresses confirm those accesses leave no trace.

// File: rtl/rlost_pkg.sv
package rlost_pkg;
  localparam int unsigned TYPE_W   = 4;
  localparam int unsigned TYPE_LSB = 8;
  localparam logic [TYPE_W-1:0] TYPE_NONE  = 4'h0;
  localparam logic [TYPE_W-1:0] TYPE_RLOST = 4'h3;

  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_MASK = 2'd1,
    RA_OFFS = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rlost_flag_bank.sv
module rlost_flag_bank #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned NFLAG = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_a,
  input  logic [NUM_CH-1:0] evt_b,
  input  logic [NFLAG-1:0]  clr_vec,
  output logic [NFLAG-1:0]  flags
);
  logic [NFLAG-1:0] set_vec;

  // interleave: packet A at even index, packet B at odd index
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map
    assign set_vec[2*ch]   = evt_a[ch];
    assign set_vec[2*ch+1] = evt_b[ch];
  end

  // a new event wins over a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/rlost_lowest_set.sv
module rlost_lowest_set #(
  parameter int unsigned W = 16,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rlost_regif.sv
module rlost_regif
  import rlost_pkg::*;
#(
  parameter int unsigned NFLAG  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned OFF_W = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NFLAG-1:0]  flags,
  input  logic              found,
  input  logic [OFF_W-1:0]  idx,
  output logic [NFLAG-1:0]  mask,
  output logic [NFLAG-1:0]  clr_vec,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(RA_FLAG);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(RA_MASK);
  localparam logic [ADDR_W-1:0] A_OFFS = ADDR_W'(RA_OFFS);

  logic hit_flag, hit_mask, hit_offs;
  logic [NFLAG-1:0] wr_clr, rd_clr;

  assign hit_flag = (bus_addr == A_FLAG);
  assign hit_mask = (bus_addr == A_MASK);
  assign hit_offs = (bus_addr == A_OFFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mask <= '1;
    else if (bus_wr && hit_mask) mask <= bus_wdata[NFLAG-1:0];
  end

  assign wr_clr = (bus_wr && hit_flag) ? bus_wdata[NFLAG-1:0] : '0;

  always_comb begin
    rd_clr = '0;
    if (bus_rd && hit_offs && found) rd_clr[idx] = 1'b1;
  end

  assign clr_vec = wr_clr | rd_clr;

  always_comb begin
    bus_rdata = '0;
    if (hit_flag) begin
      bus_rdata[NFLAG-1:0] = flags;
    end else if (hit_mask) begin
      bus_rdata[NFLAG-1:0] = mask;
    end else if (hit_offs && found) begin
      bus_rdata[OFF_W-1:0]               = idx;
      bus_rdata[TYPE_LSB +: TYPE_W]      = TYPE_RLOST;
    end
  end
endmodule

// File: rtl/rlost_irq_dispatch.sv
module rlost_irq_dispatch #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_a,
  input  logic [NUM_CH-1:0] evt_b,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned NFLAG = 2 * NUM_CH;
  localparam int unsigned OFF_W = (NFLAG > 1) ? $clog2(NFLAG) : 1;

  logic [NFLAG-1:0] flag_q, mask_q, clr_vec, pending;
  logic             found;
  logic [OFF_W-1:0] idx;

  rlost_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .clr_vec(clr_vec), .flags(flag_q)
  );

  assign pending = flag_q & mask_q;

  rlost_lowest_set #(.W(NFLAG)) u_enc (
    .req(pending), .found(found), .idx(idx)
  );

  rlost_regif #(.NFLAG(NFLAG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flag_q),
    .found(found), .idx(idx), .mask(mask_q), .clr_vec(clr_vec),
    .bus_rdata(bus_rdata)
  );

  assign irq = found;
endmodule

// File: rtl/rlost_irq_chk.sv
module rlost_irq_chk
  import rlost_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NFLAG = 2 * NUM_CH,
  localparam int unsigned OFF_W = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] evt_a,
  input logic [NUM_CH-1:0] evt_b,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NFLAG-1:0]  flags
);
  logic [NFLAG-1:0] evt_vec;
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ev
    assign evt_vec[2*ch]   = evt_a[ch];
    assign evt_vec[2*ch+1] = evt_b[ch];
  end

  // R1
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((flags & $past(evt_vec)) == $past(evt_vec)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(evt_vec)) == '0));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(RA_FLAG)) |=>
      ((flags & $past(bus_wdata[NFLAG-1:0]) & ~$past(evt_vec)) == '0));

  // R7
  offs_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(RA_OFFS) &&
     bus_rdata[TYPE_LSB +: TYPE_W] == TYPE_RLOST) |=>
      ((((flags & ~$past(evt_vec)) >> $past(bus_rdata[OFF_W-1:0])) & NFLAG'(1)) == '0));

  // R6
  idle_offs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(RA_OFFS) && !irq) |-> (bus_rdata == '0));
endmodule

bind rlost_irq_dispatch rlost_irq_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .flags(flag_q)
);

// File: tb/rlost_irq_dispatch_tb.sv
module rlost_irq_dispatch_tb;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] evt_a = '0;
  logic [NUM_CH-1:0] evt_b = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rlost_irq_dispatch #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // peek: no side effect
  task automatic peek(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // read with strobe across one clock edge, ends at negedge
  task automatic rd_strobe(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic fire(input logic [NUM_CH-1:0] a, input logic [NUM_CH-1:0] b);
    evt_a = a; evt_b = b;
    @(negedge clk); evt_a = '0; evt_b = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 irq", {31'b0, irq}, 32'h0);
    peek(2'd0, d); check("R9 flags", d, 32'h0);
    peek(2'd1, d); check("R8 mask reset", d, 32'h0000_FFFF);
    peek(2'd2, d); check("R6 idle offset", d, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    fire(8'h20, 8'h00);                 // ch5 A -> bit 10
    peek(2'd0, d); check("R1 ch5A", d, 32'h0000_0400);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    peek(2'd2, d); check("R6 offset ch5A", d, 32'h0000_030A);
    fire(8'h00, 8'h08);                 // ch3 B -> bit 7
    peek(2'd0, d); check("R2 accumulate", d, 32'h0000_0480);
    wr(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, d); check("R4 clear all", d, 32'h0);
  endtask

  task automatic t_dispatch();
    logic [31:0] d;
    fire(8'h20, 8'h00);
    fire(8'h02, 8'h08);                 // ch1 A and ch3 B together
    peek(2'd0, d); check("R2 three set", d, 32'h0000_0484);
    wr(2'd1, 32'h0000_0400);            // only ch5A enabled
    rd_strobe(2'd2, d); check("R6 report ch5A", d, 32'h0000_030A);
    peek(2'd0, d); check("R7 only ch5A cleared", d, 32'h0000_0084);
    check("R8 irq off masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0000_FFFF);
    check("R8 irq back", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0084);
    peek(2'd0, d); check("R4 w1c 84", d, 32'h0);
    check("R4 irq off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    fire(8'h02, 8'h80);                 // bits 2 and 15
    rd_strobe(2'd2, d); check("R6 lowest 2", d, 32'h0000_0302);
    rd_strobe(2'd2, d); check("R6 next 15", d, 32'h0000_030F);
    rd_strobe(2'd2, d); check("R7 empty read", d, 32'h0);
    peek(2'd0, d); check("R7 nothing left", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    fire(8'h04, 8'h01);                 // bits 4 and 1
    evt_a = 8'h04;                      // ch2 A again while clearing bits 4,1
    wr(2'd0, 32'h0000_0012);
    evt_a = '0;
    peek(2'd0, d); check("R5 write collide", d, 32'h0000_0010);
    evt_a = 8'h04;                      // read reports bit 4 while it re-fires
    rd_strobe(2'd2, d);
    evt_a = '0;
    check("R6 offset bit4", d, 32'h0000_0304);
    peek(2'd0, d); check("R5 read collide", d, 32'h0000_0010);
    wr(2'd0, 32'h0000_0010);
  endtask

  task automatic t_mask_and_unmapped();
    logic [31:0] d;
    wr(2'd1, 32'h0);
    fire(8'h00, 8'h40);                 // ch6 B -> bit 13
    check("R8 masked no irq", {31'b0, irq}, 32'h0);
    peek(2'd0, d); check("R8 masked captured", d, 32'h0000_2000);
    peek(2'd2, d); check("R6 masked offset", d, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    peek(2'd0, d); check("R10 writes ignored", d, 32'h0000_2000);
    peek(2'd3, d); check("R10 unmapped read", d, 32'h0);
    wr(2'd1, 32'h0000_2000);
    check("R8 enable irq", {31'b0, irq}, 32'h1);
    peek(2'd0, d); check("R3 upper zero", d & 32'hFFFF_0000, 32'h0);
    wr(2'd0, 32'h0000_2000);
    wr(2'd1, 32'h0000_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_dispatch();
    t_priority();
    t_collide();
    t_mask_and_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule